// File: doc/BRIEF.md
# SECDED Fault Injection and Error Reporting Unit

This unit sits between a requester and a word store inside a memory controller. Each stored word is 64 data bits plus 8 check bits of an extended Hamming (SECDED) code. On the write path the unit can corrupt the word on purpose. Two 32-bit XOR masks cover the upper and lower data halves, and an 8-bit XOR mask covers the check byte. The masks act only while an injection-enable bit is set. The check bits are always computed from the clean write data, so a corrupted bit is seen as a mismatch when the word is read.

On the read path the unit decodes the stored word. It repairs a single flipped bit, and it flags two flipped bits as uncorrectable. A correction-enable bit selects between the repaired word and the raw stored word. Errors are recorded in two sticky flags and in a saturating single-bit error counter. The single-bit flag rises only once the counter reaches a programmable threshold. A disable register can suppress the recording of each error class. Software tests its error-handling code by writing through the masks and then reading the words back.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, every register reads as zero, `rd_valid` is low and the counter is zero.
- R2: With injection enabled (register 2 bit 0), each set bit of register 0 inverts stored data bit 32+n, and each set bit of register 1 inverts stored data bit n.
- R3: With injection disabled, the data and check bits are stored exactly as encoded from the write data, whatever the three masks hold.
- R4: With injection enabled, register 2 bits [15:8] invert the matching check bits. One inverted check bit is a correctable error with the data intact, and two inverted check bits are an uncorrectable error.
- R5: `rd_valid` and `rd_data` appear one cycle after `rd_req`. With correction on (register 3 bit 0), a word holding one flipped bit returns the originally written value and `rd_corrected` is high.
- R6: With correction off, a read returns the raw stored data bits. Detection and reporting still take place.
- R7: Each recorded single-bit error increments the counter (register 6 bits [7:0]). Status bit 0 (register 5) is set once the counter reaches the threshold (register 3 bits [15:8]). A threshold of 0 or 1 sets the flag on the first error.
- R8: Two flipped bits set status bit 1, drive `rd_uncorrectable`, return the raw data and leave the counter unchanged.
- R9: Writing 1 to a status bit of register 5 clears that bit. Writing a value whose bits [7:0] are zero to register 6 resets the counter to 0.
- R10: Register 4 bit 0 suppresses the single-bit flag, the counter and `rd_corrected`. Register 4 bit 1 suppresses the double-bit flag and `rd_uncorrectable`. Correction of the data is not affected.
- R11: The counter saturates at its maximum value (255 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Register read value (combinational) |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 4 | Store write index |
| wr_data | input | 64 | Write data before injection |
| rd_req | input | 1 | Store read request |
| rd_addr | input | 4 | Store read index |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Corrected or raw read data |
| rd_corrected | output | 1 | Recorded single-bit error on this read |
| rd_uncorrectable | output | 1 | Recorded double-bit error on this read |

## Verification
The bench places single flips in both data halves and in check bits 0 and 7, where a decoder that derived its syndrome from the masked data, or that missed the overall-parity bit, would report a clean read or repair the wrong bit. It pairs a data flip with a check flip and checks two check flips on their own, so that a decoder treating any nonzero syndrome as correctable would corrupt the data instead of flagging it. It walks the counter up to the threshold of 3 and then past 255, which catches a flag that rises on the first error or a counter that wraps to zero. It also reads with correction or detection turned off, where a careless design would still repair the data or still record the error.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

  localparam int ECC_DW   = 64;
  localparam int ECC_CW   = 8;
  localparam int ECC_PW   = ECC_CW - 1;
  localparam int ECC_HALF = ECC_DW / 2;
  localparam int ECC_LAST = ECC_DW + ECC_PW;
  localparam int ECC_SPAN = ECC_LAST + 1;

  typedef struct packed {
    logic              single;
    logic              multi;
    logic [ECC_DW-1:0] fix;
  } ecc_dec_t;

  // Hamming codeword position of data bit i: the i-th position, counted
  // from 1, that is not a power of two.
  function automatic logic [ECC_PW-1:0] ecc_dpos(input int i);
    logic [ECC_PW-1:0] r;
    int idx;
    r   = '0;
    idx = 0;
    for (int p = 3; p < ECC_SPAN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (idx == i) r = ECC_PW'(p);
        idx++;
      end
    end
    return r;
  endfunction

  // Check byte: bits [6:0] are Hamming parities, and bit 7 makes the whole
  // 72-bit codeword even parity.
  function automatic logic [ECC_CW-1:0] ecc_gen(input logic [ECC_DW-1:0] d);
    logic [ECC_CW-1:0] c;
    c = '0;
    for (int i = 0; i < ECC_DW; i++) begin
      if (d[i]) c[ECC_PW-1:0] = c[ECC_PW-1:0] ^ ecc_dpos(i);
    end
    c[ECC_CW-1] = (^d) ^ (^c[ECC_PW-1:0]);
    return c;
  endfunction

  function automatic ecc_dec_t ecc_check(input logic [ECC_DW-1:0] d,
                                         input logic [ECC_CW-1:0] c);
    ecc_dec_t          r;
    logic [ECC_CW-1:0] g;
    logic [ECC_PW-1:0] s;
    logic              par;
    r   = '0;
    g   = ecc_gen(d);
    s   = g[ECC_PW-1:0] ^ c[ECC_PW-1:0];
    par = ^{d, c};
    if (par) begin
      if (s == '0 || (s & (s - ECC_PW'(1))) == '0) begin
        r.single = 1'b1;
      end else if (s > ECC_PW'(ECC_LAST)) begin
        r.multi = 1'b1;
      end else begin
        r.single = 1'b1;
        for (int i = 0; i < ECC_DW; i++) begin
          if (ecc_dpos(i) == s) r.fix[i] = 1'b1;
        end
      end
    end else if (s != '0) begin
      r.multi = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_wr_inject.sv
module ecc_wr_inject
  import ecc_inj_pkg::*;
(
  input  logic [ECC_DW-1:0]   wr_data,
  input  logic                inj_en,
  input  logic [ECC_HALF-1:0] mask_hi,
  input  logic [ECC_HALF-1:0] mask_lo,
  input  logic [ECC_CW-1:0]   mask_chk,
  output logic [ECC_DW-1:0]   st_data,
  output logic [ECC_CW-1:0]   st_chk
);

  logic [ECC_CW-1:0] clean_chk;
  logic [ECC_DW-1:0] dmask;
  logic [ECC_CW-1:0] cmask;

  always_comb begin
    clean_chk = ecc_gen(wr_data);
    dmask     = inj_en ? {mask_hi, mask_lo} : '0;
    cmask     = inj_en ? mask_chk : '0;
    st_data   = wr_data ^ dmask;
    st_chk    = clean_chk ^ cmask;
  end

  // R3: no corruption of either field while injection is off
  always_comb begin
    if (!inj_en) begin
      a_r3_clean_store : assert ({st_data, st_chk} == {wr_data, ecc_gen(wr_data)});
    end
  end

endmodule

// File: rtl/ecc_word_store.sv
module ecc_word_store
  import ecc_inj_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int WW   = ECC_DW + ECC_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rword,
  output logic          rvalid
);

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
    if (re) rword <= mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid <= 1'b0;
    else        rvalid <= re;
  end

endmodule

// File: rtl/ecc_rd_decode.sv
module ecc_rd_decode
  import ecc_inj_pkg::*;
(
  input  logic [ECC_DW-1:0] raw_data,
  input  logic [ECC_CW-1:0] raw_chk,
  input  logic              corr_en,
  output logic [ECC_DW-1:0] out_data,
  output logic              dec_single,
  output logic              dec_multi
);

  ecc_dec_t dec;

  always_comb begin
    dec        = ecc_check(raw_data, raw_chk);
    dec_single = dec.single;
    dec_multi  = dec.multi;
    out_data   = (corr_en && dec.single) ? (raw_data ^ dec.fix) : raw_data;
  end

  // R8: a word is never both correctable and uncorrectable
  always_comb begin
    a_r8_class_exclusive : assert ($onehot0({dec_single, dec_multi}));
  end

endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_single,
  input  logic             ev_multi,
  input  logic             off_sb,
  input  logic             off_mb,
  input  logic [CNT_W-1:0] thr,
  input  logic             clr_sb,
  input  logic             clr_mb,
  input  logic             cnt_clr,
  output logic             sb_evt,
  output logic             mb_evt,
  output logic             sb_flag,
  output logic             mb_flag,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_next;
  logic [CNT_W-1:0] thr_eff;
  logic             sb_hit;

  always_comb begin
    sb_evt   = ev_valid && ev_single && !off_sb;
    mb_evt   = ev_valid && ev_multi && !off_mb;
    cnt_base = cnt_clr ? '0 : cnt;
    cnt_next = (sb_evt && cnt_base != CMAX) ? cnt_base + CNT_W'(1) : cnt_base;
    thr_eff  = (thr == '0) ? CNT_W'(1) : thr;
    sb_hit   = sb_evt && (cnt_next >= thr_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sb_flag <= 1'b0;
      mb_flag <= 1'b0;
    end else begin
      cnt <= cnt_next;
      if (sb_hit)      sb_flag <= 1'b1;
      else if (clr_sb) sb_flag <= 1'b0;
      if (mb_evt)      mb_flag <= 1'b1;
      else if (clr_mb) mb_flag <= 1'b0;
    end
  end

  // R7: the single-bit flag rises only after a recorded single-bit error
  a_r7_flag_cause : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_flag) |-> $past(sb_evt));

  // R8: a double-bit error leaves the counter alone
  a_r8_no_count : assert property (@(posedge clk) disable iff (!rst_n)
    (mb_evt && !cnt_clr) |=> (cnt == $past(cnt)));

  // R10: suppressed single-bit errors are not counted
  a_r10_sb_muted : assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_single && off_sb && !cnt_clr) |=> (cnt == $past(cnt)));

  // R9: a clear without a new recorded error drops the flag
  a_r9_w1c : assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sb && !sb_evt) |=> !sb_flag);

  // R11: the counter holds at its maximum
  a_r11_saturate : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !cnt_clr) |=> (cnt == CMAX));

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int RAW  = 3,
  localparam int RW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [ECC_DW-1:0] wr_data,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_valid,
  output logic [ECC_DW-1:0] rd_data,
  output logic              rd_corrected,
  output logic              rd_uncorrectable
);

  localparam logic [RAW-1:0] A_MHI  = 3'd0;
  localparam logic [RAW-1:0] A_MLO  = 3'd1;
  localparam logic [RAW-1:0] A_INJ  = 3'd2;
  localparam logic [RAW-1:0] A_CFG  = 3'd3;
  localparam logic [RAW-1:0] A_OFF  = 3'd4;
  localparam logic [RAW-1:0] A_STAT = 3'd5;
  localparam logic [RAW-1:0] A_CNT  = 3'd6;

  logic [ECC_HALF-1:0] mask_hi, mask_lo;
  logic [ECC_CW-1:0]   mask_chk;
  logic                inj_en;
  logic                corr_en;
  logic [CNT_W-1:0]    thr;
  logic                off_sb, off_mb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi  <= '0;
      mask_lo  <= '0;
      mask_chk <= '0;
      inj_en   <= 1'b0;
      corr_en  <= 1'b0;
      thr      <= '0;
      off_sb   <= 1'b0;
      off_mb   <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_MHI: mask_hi <= reg_wdata;
        A_MLO: mask_lo <= reg_wdata;
        A_INJ: begin
          inj_en   <= reg_wdata[0];
          mask_chk <= reg_wdata[8 +: ECC_CW];
        end
        A_CFG: begin
          corr_en <= reg_wdata[0];
          thr     <= reg_wdata[8 +: CNT_W];
        end
        A_OFF: begin
          off_sb <= reg_wdata[0];
          off_mb <= reg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  logic clr_sb, clr_mb, cnt_clr;
  always_comb begin
    clr_sb  = reg_we && reg_addr == A_STAT && reg_wdata[0];
    clr_mb  = reg_we && reg_addr == A_STAT && reg_wdata[1];
    cnt_clr = reg_we && reg_addr == A_CNT && reg_wdata[CNT_W-1:0] == '0;
  end

  logic [ECC_DW-1:0] st_data;
  logic [ECC_CW-1:0] st_chk;

  ecc_wr_inject u_wr (
    .wr_data (wr_data),
    .inj_en  (inj_en),
    .mask_hi (mask_hi),
    .mask_lo (mask_lo),
    .mask_chk(mask_chk),
    .st_data (st_data),
    .st_chk  (st_chk)
  );

  logic [ECC_DW+ECC_CW-1:0] rword;

  ecc_word_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wword ({st_chk, st_data}),
    .re    (rd_req),
    .raddr (rd_addr),
    .rword (rword),
    .rvalid(rd_valid)
  );

  logic dec_single, dec_multi;

  ecc_rd_decode u_dec (
    .raw_data  (rword[ECC_DW-1:0]),
    .raw_chk   (rword[ECC_DW +: ECC_CW]),
    .corr_en   (corr_en),
    .out_data  (rd_data),
    .dec_single(dec_single),
    .dec_multi (dec_multi)
  );

  logic             sb_evt, mb_evt, sb_flag, mb_flag;
  logic [CNT_W-1:0] cnt;

  ecc_err_report #(.CNT_W(CNT_W)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (rd_valid),
    .ev_single(dec_single),
    .ev_multi (dec_multi),
    .off_sb   (off_sb),
    .off_mb   (off_mb),
    .thr      (thr),
    .clr_sb   (clr_sb),
    .clr_mb   (clr_mb),
    .cnt_clr  (cnt_clr),
    .sb_evt   (sb_evt),
    .mb_evt   (mb_evt),
    .sb_flag  (sb_flag),
    .mb_flag  (mb_flag),
    .cnt      (cnt)
  );

  assign rd_corrected     = sb_evt;
  assign rd_uncorrectable = mb_evt;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MHI:  reg_rdata = mask_hi;
      A_MLO:  reg_rdata = mask_lo;
      A_INJ:  begin
        reg_rdata[0]            = inj_en;
        reg_rdata[8 +: ECC_CW]  = mask_chk;
      end
      A_CFG:  begin
        reg_rdata[0]            = corr_en;
        reg_rdata[8 +: CNT_W]   = thr;
      end
      A_OFF:  reg_rdata[1:0] = {off_mb, off_sb};
      A_STAT: reg_rdata[1:0] = {mb_flag, sb_flag};
      A_CNT:  reg_rdata[CNT_W-1:0] = cnt;
      default: ;
    endcase
  end

  // R5: one-cycle read latency
  a_r5_read_latency : assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  a_r5_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

endmodule

// File: tb/ecc_inject_ctrl_bench.sv
module ecc_inject_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic        rd_corrected;
  logic        rd_uncorrectable;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ecc_inject_ctrl u_ecc_inject_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mem_wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns data and per-read flags; status registers are settled on return
  task automatic mem_rd(input logic [3:0] a, output logic [63:0] d,
                        output logic c, output logic u, output logic v);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
    d = rd_data; c = rd_corrected; u = rd_uncorrectable; v = rd_valid;
    @(negedge clk);
  endtask

  task automatic clear_status();
    reg_wr(3'd5, 32'h3);
    reg_wr(3'd6, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    for (int a = 0; a < 7; a++) begin
      reg_rd(3'(a), r);
      chk($sformatf("R1 reg%0d after reset", a), 64'(r), 64'h0);
    end
    chk("R1 rd_valid after reset", 64'(rd_valid), 64'h0);
  endtask

  task automatic t_no_inject();
    logic [63:0] d; logic c, u, v; logic [31:0] r;
    clear_status();
    reg_wr(3'd0, 32'hFFFF_0000);
    reg_wr(3'd1, 32'h0000_00FF);
    reg_wr(3'd2, 32'h0000_FF00);
    reg_wr(3'd3, 32'h0000_0000);
    mem_wr(4'd0, 64'hDEAD_BEEF_0BAD_F00D);
    mem_rd(4'd0, d, c, u, v);
    chk("R3 raw data with masks but injection off", d, 64'hDEAD_BEEF_0BAD_F00D);
    chk("R3 no error flagged", 64'({c, u}), 64'h0);
    reg_rd(3'd5, r);
    chk("R3 status clean", 64'(r), 64'h0);
  endtask

  task automatic t_data_inject();
    logic [63:0] d; logic c, u, v;
    reg_wr(3'd0, 32'h8000_0000);
    reg_wr(3'd1, 32'h0000_0001);
    reg_wr(3'd2, 32'h0000_0001);
    mem_wr(4'd1, 64'h0);
    reg_wr(3'd3, 32'h0);
    mem_rd(4'd1, d, c, u, v);
    chk("R2 raw stored word with both halves masked", d, 64'h8000_0000_0000_0001);
    chk("R5 rd_valid one cycle after request", 64'(v), 64'h1);
    reg_wr(3'd0, 32'h0000_0020);
    reg_wr(3'd1, 32'h0);
    mem_wr(4'd3, 64'h1111_2222_3333_4444);
    reg_wr(3'd2, 32'h0);
    reg_wr(3'd3, 32'h0000_0001);
    mem_rd(4'd3, d, c, u, v);
    chk("R2 upper-half single flip corrected", d, 64'h1111_2222_3333_4444);
    chk("R5 rd_corrected on upper flip", 64'(c), 64'h1);
    clear_status();
    mem_rd(4'd1, d, c, u, v);
    chk("R8 two data flips returned raw", d, 64'h8000_0000_0000_0001);
    chk("R8 rd_uncorrectable", 64'({c, u}), 64'h1);
    reg_rd(3'd5, d[31:0]);
    chk("R8 status multi flag only", 64'(d[31:0]), 64'h2);
    reg_rd(3'd6, d[31:0]);
    chk("R8 counter untouched", 64'(d[31:0]), 64'h0);
  endtask

  task automatic t_single_correct();
    logic [63:0] d; logic c, u, v; logic [31:0] r;
    clear_status();
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd1, 32'h0000_0001);
    reg_wr(3'd2, 32'h0000_0001);
    mem_wr(4'd2, 64'h0);
    reg_wr(3'd2, 32'h0);
    reg_wr(3'd3, 32'h0000_0001);
    mem_rd(4'd2, d, c, u, v);
    chk("R5 injected low bit reads back as zero", d, 64'h0);
    reg_rd(3'd5, r);
    chk("R7 threshold 0 flags first error", 64'(r), 64'h1);
    reg_rd(3'd6, r);
    chk("R7 counter after first error", 64'(r), 64'h1);
    reg_wr(3'd3, 32'h0);
    mem_rd(4'd2, d, c, u, v);
    chk("R6 correction off returns raw", d, 64'h1);
    reg_rd(3'd6, r);
    chk("R6 still counted with correction off", 64'(r), 64'h2);
  endtask

  task automatic t_threshold();
    logic [63:0] d; logic c, u, v; logic [31:0] r;
    clear_status();
    reg_rd(3'd5, r);
    chk("R9 W1C cleared flags", 64'(r), 64'h0);
    reg_rd(3'd6, r);
    chk("R9 counter reset by zero write", 64'(r), 64'h0);
    reg_wr(3'd3, 32'h0000_0301);
    for (int k = 1; k <= 2; k++) begin
      mem_rd(4'd2, d, c, u, v);
      reg_rd(3'd5, r);
      chk($sformatf("R7 below threshold after %0d", k), 64'(r), 64'h0);
    end
    mem_rd(4'd2, d, c, u, v);
    reg_rd(3'd5, r);
    chk("R7 flag at threshold 3", 64'(r), 64'h1);
    reg_rd(3'd6, r);
    chk("R7 counter at 3", 64'(r), 64'h3);
  endtask

  task automatic t_check_inject();
    logic [63:0] d; logic c, u, v; logic [31:0] r;
    clear_status();
    reg_wr(3'd3, 32'h0000_0001);
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd1, 32'h0);
    reg_wr(3'd2, 32'h0000_0101);
    mem_wr(4'd4, 64'h0123_4567_89AB_CDEF);
    reg_wr(3'd2, 32'h0000_8001);
    mem_wr(4'd5, 64'hFEDC_BA98_7654_3210);
    reg_wr(3'd2, 32'h0000_0301);
    mem_wr(4'd6, 64'h0F0F_0F0F_F0F0_F0F0);
    reg_wr(3'd1, 32'h0000_0004);
    reg_wr(3'd2, 32'h0000_0101);
    mem_wr(4'd7, 64'h0);
    reg_wr(3'd2, 32'h0);
    mem_rd(4'd4, d, c, u, v);
    chk("R4 check bit 0 flip keeps data", d, 64'h0123_4567_89AB_CDEF);
    chk("R4 check bit 0 flip is single", 64'({c, u}), 64'h2);
    mem_rd(4'd5, d, c, u, v);
    chk("R4 check bit 7 flip keeps data", d, 64'hFEDC_BA98_7654_3210);
    chk("R4 check bit 7 flip is single", 64'({c, u}), 64'h2);
    reg_rd(3'd6, r);
    chk("R4 two check-bit singles counted", 64'(r), 64'h2);
    mem_rd(4'd6, d, c, u, v);
    chk("R4 two check flips uncorrectable", 64'({c, u}), 64'h1);
    chk("R8 data raw for check-pair error", d, 64'h0F0F_0F0F_F0F0_F0F0);
    mem_rd(4'd7, d, c, u, v);
    chk("R8 data+check flip uncorrectable", 64'({c, u}), 64'h1);
    chk("R8 data+check flip data raw", d, 64'h4);
    reg_rd(3'd6, r);
    chk("R8 counter unchanged by doubles", 64'(r), 64'h2);
    reg_rd(3'd5, r);
    chk("R8 both flags set", 64'(r), 64'h3);
    reg_wr(3'd5, 32'h2);
    reg_rd(3'd5, r);
    chk("R9 W1C clears only multi flag", 64'(r), 64'h1);
  endtask

  task automatic t_disable();
    logic [63:0] d; logic c, u, v; logic [31:0] r;
    clear_status();
    reg_wr(3'd4, 32'h1);
    mem_rd(4'd2, d, c, u, v);
    chk("R10 data still corrected with sb reporting off", d, 64'h0);
    chk("R10 rd_corrected muted", 64'(c), 64'h0);
    reg_rd(3'd6, r);
    chk("R10 counter muted", 64'(r), 64'h0);
    reg_rd(3'd5, r);
    chk("R10 sb flag muted", 64'(r), 64'h0);
    reg_wr(3'd4, 32'h2);
    mem_rd(4'd6, d, c, u, v);
    chk("R10 rd_uncorrectable muted", 64'(u), 64'h0);
    reg_rd(3'd5, r);
    chk("R10 mb flag muted", 64'(r), 64'h0);
    reg_wr(3'd4, 32'h0);
  endtask

  task automatic t_saturate();
    logic [63:0] d; logic c, u, v; logic [31:0] r;
    clear_status();
    reg_wr(3'd3, 32'h0000_0001);
    for (int k = 0; k < 260; k++) mem_rd(4'd2, d, c, u, v);
    reg_rd(3'd6, r);
    chk("R11 counter saturates at 255", 64'(r), 64'd255);
    reg_wr(3'd6, 32'h0000_0100);
    reg_rd(3'd6, r);
    chk("R9 write with zero low byte resets counter", 64'(r), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_no_inject();
    t_data_inject();
    t_single_correct();
    t_threshold();
    t_check_inject();
    t_disable();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule